// File: doc/BRIEF.md
# Transmit Line Output Formatter

This block turns a serial transmit bit stream into the digital signals a line front end needs. It has two output stages. The first is a dual-rail pair of pulse outputs for an external bipolar line driver, where marks alternate between the two rails. The second is a single-rail unipolar output for an optical link, coded either as NRZ or as CMI. Every output can be put into a high-impedance state, and each stage has its own output-enable signal.

The block runs from a clock at twice the bit rate. The `bit_en` input is asserted for one cycle per bit period, and on that cycle `tx_bit` is taken in. The following two clock cycles are the first and second halves of that bit, so the block can form half-width pulses and the mid-bit transitions that CMI needs. The bit rate for E1 is 2048 kbit/s and for T1 is 1544 kbit/s. This changes only the clock speed, not the logic.

Static configuration inputs set the following:
- which output stage is active;
- the pulse width;
- a shared polarity inversion;
- NRZ or CMI coding on the single rail.

Top module: `tx_line_formatter`

## Requirements
- R1: The dual-rail stage is enabled (`rail_oe`=1) exactly when, at the previous clock edge, `rail_sel`=1, `line_sel`=1 and `loop_ctl`=0.
- R2: The single-rail stage is enabled (`uni_oe`=1) exactly when, at the previous clock edge, `rail_sel`=1, `line_sel`=0 and `loop_ctl`=0. In that state `cmi_sel`=0 selects NRZ and `cmi_sel`=1 selects CMI. Any other combination, including `loop_ctl`=1, disables both stages.
- R3: After reset both output-enables are 0 and all three data pins are high-impedance. They stay that way until `rail_sel` has been seen at 1 at a clock edge.
- R4: In dual-rail mode, `full_width`=0 makes a mark active only in the first half of its bit period. `full_width`=1 keeps it active for both halves.
- R5: In dual-rail mode, successive 1 bits go alternately to the positive rail and the negative rail. A 0 bit leaves both rails inactive.
- R6: With `pol_inv`=0 the dual-rail pins are active low and the single-rail pin is active high. With `pol_inv`=1 all three data pins are inverted.
- R7: In NRZ mode the single-rail level equals the bit for both halves of its bit period.
- R8: In CMI mode, a 0 bit is low in the first half and high in the second half. A 1 bit is a level that alternates from one 1 to the next, and it starts high.
- R9: In CMI mode with `full_width`=0, a 1 sent at the high level is high only in the first half and low in the second. With `full_width`=1 it is high for the whole bit. A 1 sent at the low level is low for the whole bit.
- R10: The mark alternation state is cleared by reset and by any change of output mode among off, dual-rail, NRZ and CMI. The first 1 after either event is a positive-rail mark (dual) or a high level (CMI).
- R11: A bit taken in on a clock edge with `bit_en`=1 appears on the pins in the cycle that follows that edge (first half). The next cycle, when `bit_en`=0, is the second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Starts a new bit period and takes in `tx_bit` |
| tx_bit | input | 1 | Serial transmit data |
| rail_sel | input | 1 | Enables the output stages when 1 |
| line_sel | input | 1 | 1 selects dual-rail, 0 selects single-rail |
| loop_ctl | input | 1 | Forces both stages off when 1 |
| cmi_sel | input | 1 | Single-rail coding: 0 selects NRZ, 1 selects CMI |
| full_width | input | 1 | Pulse width: 0 gives half-bit pulses, 1 gives whole-bit pulses |
| pol_inv | input | 1 | Inverts every data pin |
| pos_rail | output | 1 | Positive-mark rail, high-impedance when disabled |
| neg_rail | output | 1 | Negative-mark rail, high-impedance when disabled |
| uni_out | output | 1 | Single-rail data, high-impedance when disabled |
| rail_oe | output | 1 | Dual-rail output enable |
| uni_oe | output | 1 | Single-rail output enable |

## Verification
Every active mode is driven with the same sixteen-bit patterns, in each combination of pulse width and polarity. Both halves of every bit are sampled, so a half-width pulse can be told apart from a full-width one, and CMI's mid-bit rise on a 0 can be told apart from an NRZ level. The patterns contain runs of ones, isolated ones and runs of zeros. These show whether the alternation advances only on marks and whether a 0 leaves the rails idle. Separate sequences switch the mode, or assert reset, between marks, to show that the first mark afterwards is positive again. The control combinations that must leave both stages disabled are tried as well.

// File: rtl/txfmt_pkg.sv
`timescale 1ns/1ps
package txfmt_pkg;

  typedef enum logic [1:0] {
    TXM_OFF  = 2'd0,
    TXM_DUAL = 2'd1,
    TXM_NRZ  = 2'd2,
    TXM_CMI  = 2'd3
  } txm_mode_e;

  // Stage selection from the control inputs
  function automatic txm_mode_e pick_mode(input logic rail, input logic line,
                                          input logic loop, input logic cmi);
    if (!rail || loop) return TXM_OFF;
    if (line)          return TXM_DUAL;
    return cmi ? TXM_CMI : TXM_NRZ;
  endfunction

  // A pulse is on in the first half always, in the second half only at full width
  function automatic logic pulse_window(input logic full, input logic half2);
    return full | ~half2;
  endfunction

  // {positive, negative} rail activity for one half-bit
  function automatic logic [1:0] ami_activity(input logic b, input logic neg_mark,
                                              input logic full, input logic half2);
    logic on;
    on = b & pulse_window(full, half2);
    return {on & ~neg_mark, on & neg_mark};
  endfunction

  // CMI activity (high level) for one half-bit
  function automatic logic cmi_activity(input logic b, input logic low_mark,
                                        input logic full, input logic half2);
    if (!b) return half2;
    return ~low_mark & pulse_window(full, half2);
  endfunction

endpackage

// File: rtl/txfmt_mode.sv
`timescale 1ns/1ps
module txfmt_mode
  import txfmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rail_sel,
  input  logic      line_sel,
  input  logic      loop_ctl,
  input  logic      cmi_sel,
  output txm_mode_e mode_q,
  output logic      mode_chg
);
  txm_mode_e mode_d;

  always_comb begin
    mode_d   = pick_mode(rail_sel, line_sel, loop_ctl, cmi_sel);
    mode_chg = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TXM_OFF;
    else        mode_q <= mode_d;
  end

  AST_OFF_WHEN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_ctl) |-> mode_q == TXM_OFF) else $error("loop did not disable"); // R2

endmodule

// File: rtl/txfmt_seq.sv
`timescale 1ns/1ps
module txfmt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_bit,
  input  logic mode_chg,
  output logic cur_bit,
  output logic cur_mark,
  output logic half2
);
  logic alt_q;
  logic alt_base;

  // Alternation restarts on a mode change
  assign alt_base = mode_chg ? 1'b0 : alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q    <= 1'b0;
      cur_bit  <= 1'b0;
      cur_mark <= 1'b0;
      half2    <= 1'b1;
    end else if (bit_en) begin
      cur_bit  <= tx_bit;
      cur_mark <= alt_base;
      alt_q    <= alt_base ^ tx_bit;
      half2    <= 1'b0;
    end else begin
      alt_q    <= alt_base;
      half2    <= 1'b1;
    end
  end

  AST_FIRST_MARK_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && bit_en && tx_bit) |=> !cur_mark) else $error("first mark not positive"); // R10

  AST_BIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (cur_bit == $past(tx_bit)) && !half2) else $error("bit not taken"); // R11

endmodule

// File: rtl/txfmt_enc.sv
`timescale 1ns/1ps
module txfmt_enc
  import txfmt_pkg::*;
(
  input  txm_mode_e mode_q,
  input  logic      cur_bit,
  input  logic      cur_mark,
  input  logic      half2,
  input  logic      full_width,
  input  logic      pol_inv,
  output logic      pos_act,
  output logic      neg_act,
  output logic      uni_act,
  output logic      pos_lvl,
  output logic      neg_lvl,
  output logic      uni_lvl
);
  logic [1:0] ami;

  always_comb begin
    ami     = ami_activity(cur_bit, cur_mark, full_width, half2);
    pos_act = ami[1];
    neg_act = ami[0];
    if (mode_q == TXM_CMI) uni_act = cmi_activity(cur_bit, cur_mark, full_width, half2);
    else                   uni_act = cur_bit;
    // dual rails idle high by default, single rail idle low by default
    pos_lvl = ~(pos_act ^ pol_inv);
    neg_lvl = ~(neg_act ^ pol_inv);
    uni_lvl = uni_act ^ pol_inv;
  end

endmodule

// File: rtl/tx_line_formatter.sv
`timescale 1ns/1ps
module tx_line_formatter
  import txfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_bit,
  input  logic rail_sel,
  input  logic line_sel,
  input  logic loop_ctl,
  input  logic cmi_sel,
  input  logic full_width,
  input  logic pol_inv,
  output wire  pos_rail,
  output wire  neg_rail,
  output wire  uni_out,
  output logic rail_oe,
  output logic uni_oe
);
  txm_mode_e mode_q;
  logic mode_chg;
  logic cur_bit, cur_mark, half2;
  logic pos_act, neg_act, uni_act;
  logic pos_lvl, neg_lvl, uni_lvl;

  txfmt_mode u_mode (
    .clk(clk), .rst_n(rst_n), .rail_sel(rail_sel), .line_sel(line_sel),
    .loop_ctl(loop_ctl), .cmi_sel(cmi_sel), .mode_q(mode_q), .mode_chg(mode_chg)
  );

  txfmt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit), .mode_chg(mode_chg),
    .cur_bit(cur_bit), .cur_mark(cur_mark), .half2(half2)
  );

  txfmt_enc u_enc (
    .mode_q(mode_q), .cur_bit(cur_bit), .cur_mark(cur_mark), .half2(half2),
    .full_width(full_width), .pol_inv(pol_inv),
    .pos_act(pos_act), .neg_act(neg_act), .uni_act(uni_act),
    .pos_lvl(pos_lvl), .neg_lvl(neg_lvl), .uni_lvl(uni_lvl)
  );

  assign rail_oe = (mode_q == TXM_DUAL);
  assign uni_oe  = (mode_q == TXM_NRZ) || (mode_q == TXM_CMI);

  assign pos_rail = rail_oe ? pos_lvl : 1'bz;
  assign neg_rail = rail_oe ? neg_lvl : 1'bz;
  assign uni_out  = uni_oe  ? uni_lvl : 1'bz;

  AST_DUAL_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    rail_oe |-> $past(rail_sel && line_sel && !loop_ctl)) else $error("dual enable"); // R1

  AST_UNI_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    uni_oe |-> $past(rail_sel && !line_sel && !loop_ctl)) else $error("single enable"); // R2

  AST_STAGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_oe && uni_oe)) else $error("both stages on"); // R3

  AST_RAILS_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_act && neg_act)) else $error("both rails active"); // R5

  AST_HALF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_oe && !full_width && half2) |-> !pos_act && !neg_act) else $error("half pulse"); // R4

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_oe && $past(rail_oe) && full_width && half2 && $stable(full_width))
      |-> $stable(pos_act) && $stable(neg_act)) else $error("full pulse"); // R4

  AST_NRZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TXM_NRZ && $past(mode_q == TXM_NRZ) && half2) |-> $stable(uni_act))
    else $error("nrz hold"); // R7

  AST_CMI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TXM_CMI && !cur_bit) |-> uni_act == half2) else $error("cmi zero"); // R8

endmodule

// File: tb/tx_line_formatter_test.sv
`timescale 1ns/1ps
module tx_line_formatter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, tx_bit = 1'b0;
  logic rail_sel = 1'b0, line_sel = 1'b0, loop_ctl = 1'b0, cmi_sel = 1'b0;
  logic full_width = 1'b0, pol_inv = 1'b0;
  wire  pos_rail, neg_rail, uni_out;
  logic rail_oe, uni_oe;

  int checks = 0;
  int fails = 0;
  int mode_sel;   // 1 dual, 2 nrz, 3 cmi
  logic alt;      // 1: next mark is negative / low

  always #2.5 clk = ~clk;

  tx_line_formatter uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
    .rail_sel(rail_sel), .line_sel(line_sel), .loop_ctl(loop_ctl), .cmi_sel(cmi_sel),
    .full_width(full_width), .pol_inv(pol_inv),
    .pos_rail(pos_rail), .neg_rail(neg_rail), .uni_out(uni_out),
    .rail_oe(rail_oe), .uni_oe(uni_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Set mode (at a negedge) and let one edge register it
  task automatic set_mode(input int m);
    mode_sel = m;
    rail_sel = (m != 0);
    line_sel = (m == 1);
    cmi_sel  = (m == 3);
    loop_ctl = 1'b0;
    @(posedge clk); @(negedge clk);
    alt = 1'b0;
  endtask

  // Compare one half-bit against the expected pins
  task automatic compare(input string req, input logic b, input logic m, input logic h2);
    logic win, pa, na, ua;
    win = full_width || !h2;
    if (mode_sel == 1) begin
      pa = b && !m && win;
      na = b && m && win;
      check(req, pos_rail, pol_inv ? pa : !pa);
      check(req, neg_rail, pol_inv ? na : !na);
    end else begin
      if (mode_sel == 2)  ua = b;
      else if (b)         ua = !m && win;
      else                ua = h2;
      check(req, uni_out, pol_inv ? !ua : ua);
    end
  endtask

  task automatic send(input string req, input logic b);
    logic m;
    m = alt;
    if (b) alt = !alt;
    bit_en = 1'b1; tx_bit = b;
    @(posedge clk); @(negedge clk);
    bit_en = 1'b0;
    compare(req, b, m, 1'b0);
    @(posedge clk); @(negedge clk);
    compare(req, b, m, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    string rq;
    pats[0] = 16'b1111_0000_1010_0110;
    pats[1] = 16'b0100_0111_1100_1001;
    pats[2] = 16'b1000_0001_1111_1110;
    pats[3] = 16'b0011_0101_0000_1101;
    mode_sel = 0; alt = 1'b0;

    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 rail_oe in reset", rail_oe, 1'b0);
    check("R3 uni_oe in reset", uni_oe, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 rail_oe off until rail_sel", rail_oe, 1'b0);
    check("R3 uni_oe off until rail_sel", uni_oe, 1'b0);

    // R1/R2: loop control forces off
    rail_sel = 1; line_sel = 1; loop_ctl = 1;
    @(posedge clk); @(negedge clk);
    check("R1 loop disables dual", rail_oe, 1'b0);
    line_sel = 0;
    @(posedge clk); @(negedge clk);
    check("R2 loop disables single", uni_oe, 1'b0);
    loop_ctl = 0;
    @(posedge clk); @(negedge clk);
    check("R2 single enabled", uni_oe, 1'b1);
    check("R2 dual off in single", rail_oe, 1'b0);
    line_sel = 1;
    @(posedge clk); @(negedge clk);
    check("R1 dual enabled", rail_oe, 1'b1);
    check("R1 single off in dual", uni_oe, 1'b0);

    // Sweep modes, widths, polarities, patterns
    for (int m = 1; m <= 3; m++) begin
      for (int fw = 0; fw < 2; fw++) begin
        for (int pi = 0; pi < 2; pi++) begin
          set_mode(0);
          check("R3 off between runs", rail_oe | uni_oe, 1'b0);
          full_width = fw[0]; pol_inv = pi[0];
          set_mode(m);
          if (m == 1) rq = fw ? "R4 R5 R6 dual full" : "R4 R5 R6 dual half";
          else if (m == 2) rq = "R6 R7 nrz";
          else rq = fw ? "R6 R8 R9 cmi full" : "R6 R8 R9 cmi half";
          for (int p = 0; p < 4; p++)
            for (int i = 15; i >= 0; i--) send(rq, pats[p][i]);
        end
      end
    end

    // R10: mode change clears alternation
    full_width = 0; pol_inv = 0;
    set_mode(1);
    send("R5 first mark", 1'b1);
    set_mode(2);
    set_mode(1);
    send("R10 after mode change", 1'b1);
    send("R10 next mark negative", 1'b1);
    set_mode(3);
    send("R10 cmi first high", 1'b1);
    set_mode(1);
    send("R10 dual after cmi", 1'b1);
    // R10: reset clears alternation
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 reset disables", rail_oe, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    alt = 1'b0; mode_sel = 1;
    send("R10 after reset", 1'b1);

    // R11: bit visible only after the enable edge
    bit_en = 1'b1; tx_bit = 1'b1;
    #1;
    check("R11 not yet taken", pos_rail, 1'b1);
    check("R11 neg not yet taken", neg_rail, 1'b1);
    @(posedge clk); @(negedge clk);
    bit_en = 1'b0;
    check("R11 first half shows bit", neg_rail, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule